// File: doc/BRIEF.md
# Interrupt Exception Entry Sequencer

This block is the processor-side logic that takes an interrupt once the interrupt controller has accepted it. It holds the request until the pipeline reports an instruction boundary. At that boundary it captures the event code, saves the status word and the program counter into their shadow registers, and raises the block, privilege and bank bits. It then sends fetch to the handler at the vector base plus a fixed offset. A return-from-exception strobe brings back the saved status word and sends fetch to the saved program counter.

The block owns the status word (`sr`). Software changes it through a write port (`sr_we`/`sr_wdata`), and that write is how a handler clears the block bit. The state machine has five states. RUN is normal execution. ARMED means a request is held and the block waits for a boundary. ENTRY is the one-cycle handler redirect. BLOCKED means the handler is running with the block bit set. RETURN is the one-cycle redirect to the saved PC.

The transitions are as follows. RUN→ARMED when a request is present and BL is clear. ARMED→ENTRY at a boundary. ARMED→RUN when the request is withdrawn or BL becomes set. ENTRY→BLOCKED always. BLOCKED→RUN when BL reads clear. RUN, ARMED or BLOCKED→RETURN on a return strobe. RETURN→RUN always.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `sr` is 0x5000_0000 (bit 30 = privilege mode MD, bit 28 = block BL). `ssr`, `spc`, `evt_a` and `evt_b` are zero, and `redirect` is low.
- R2: A held request is taken only in a cycle where `insn_end` is high, and only after it has been seen for at least one earlier cycle with BL clear. `redirect` rises in the next cycle. While `insn_end` stays low, no entry happens.
- R3: On entry, `evt_a` and `evt_b` both load `irq_code`.
- R4: On entry, `ssr` loads the `sr` value of the boundary cycle, and `spc` loads `pc_cur` of that cycle.
- R5: On entry, `sr` bits 30 (MD), 29 (RB) and 28 (BL) become 1. The mask field, bits 7:4, and every other bit keep their value.
- R6: The entry redirect lasts exactly one cycle, with `redirect_pc` equal to the boundary-cycle `vbr` plus 0x600.
- R7: While BL is 1, requests and boundaries cause no redirect and change no shadow or event register. A request still held when software clears BL through `sr_we` is then taken.
- R8: A `rte` pulse, given when `redirect` is low, loads `sr` from `ssr` at that edge. In the next cycle it gives a one-cycle redirect to `spc`.
- R9: A request that drops before any boundary is lost. A later boundary then causes no entry and leaves the event registers as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Accepted interrupt request from the controller (level) |
| irq_code | input | CODE_W | Event code of the request |
| insn_end | input | 1 | Instruction boundary strobe |
| pc_cur | input | XLEN | PC of the instruction boundary |
| vbr | input | XLEN | Vector base |
| rte | input | 1 | Return-from-exception strobe |
| sr_we | input | 1 | Software write of the status word |
| sr_wdata | input | XLEN | Status word write data |
| redirect | output | 1 | Fetch redirect pulse |
| redirect_pc | output | XLEN | Fetch redirect address |
| sr | output | XLEN | Status word |
| ssr | output | XLEN | Saved status word |
| spc | output | XLEN | Saved PC |
| evt_a | output | CODE_W | First event register |
| evt_b | output | CODE_W | Second event register |

## Verification
The bench targets the places where the timing of the handoff can go wrong:
- A request that arrives while the block bit is still set. A design that ignored BL would nest and overwrite `ssr`/`spc`.
- A request withdrawn before any boundary. Sampling it late would enter with a stale code.
- A pending request taken right after software clears BL. Losing it would hang the handler path.
- Random status words with different mask fields. A design that disturbed bits 7:4 or missed one of the three forced bits fails the status check.
- Return strobes. Restoring from the wrong shadow register, or redirecting twice, shows up at `redirect_pc` and `sr`.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_ARMED   = 3'd1,
        ST_ENTRY   = 3'd2,
        ST_BLOCKED = 3'd3,
        ST_RETURN  = 3'd4
    } ient_state_e;

    localparam int unsigned SR_MD_BIT = 30;
    localparam int unsigned SR_RB_BIT = 29;
    localparam int unsigned SR_BL_BIT = 28;

endpackage

// File: rtl/ientry_fsm.sv
module ientry_fsm
    import irq_entry_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_req,
    input  logic insn_end,
    input  logic rte,
    input  logic bl,
    output logic take,
    output logic do_rte,
    output logic redirect,
    output logic sel_ret
);

    ient_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (rte)                 state_d = ST_RETURN;
                else if (irq_req && !bl) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (rte)                 state_d = ST_RETURN;
                else if (!irq_req || bl) state_d = ST_RUN;
                else if (insn_end)       state_d = ST_ENTRY;
            end
            ST_ENTRY:   state_d = ST_BLOCKED;
            ST_BLOCKED: begin
                if (rte)                 state_d = ST_RETURN;
                else if (!bl)            state_d = ST_RUN;
            end
            ST_RETURN:  state_d = ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    always_comb begin
        take     = 1'b0;
        do_rte   = 1'b0;
        redirect = 1'b0;
        sel_ret  = 1'b0;
        unique case (state_q)
            ST_RUN, ST_BLOCKED: do_rte = rte;
            ST_ARMED: begin
                do_rte = rte;
                take   = !rte && irq_req && !bl && insn_end;
            end
            ST_ENTRY:  redirect = 1'b1;
            ST_RETURN: begin
                redirect = 1'b1;
                sel_ret  = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ientry_ctx.sv
module ientry_ctx
    import irq_entry_pkg::*;
#(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              do_rte,
    input  logic              sr_we,
    input  logic [XLEN-1:0]   sr_wdata,
    input  logic [XLEN-1:0]   pc_cur,
    input  logic [CODE_W-1:0] irq_code,
    output logic [XLEN-1:0]   sr,
    output logic [XLEN-1:0]   ssr,
    output logic [XLEN-1:0]   spc,
    output logic [CODE_W-1:0] evt_a,
    output logic [CODE_W-1:0] evt_b
);

    localparam logic [XLEN-1:0] SR_RESET =
        (XLEN'(1) << SR_MD_BIT) | (XLEN'(1) << SR_BL_BIT);
    localparam logic [XLEN-1:0] SR_FORCE =
        (XLEN'(1) << SR_MD_BIT) | (XLEN'(1) << SR_RB_BIT) | (XLEN'(1) << SR_BL_BIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= SR_RESET;
        end else if (do_rte) begin
            sr <= ssr;
        end else if (take) begin
            sr <= sr | SR_FORCE;
        end else if (sr_we) begin
            sr <= sr_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ssr   <= '0;
            spc   <= '0;
            evt_a <= '0;
            evt_b <= '0;
        end else if (take) begin
            ssr   <= sr;
            spc   <= pc_cur;
            evt_a <= irq_code;
            evt_b <= irq_code;
        end
    end

endmodule

// File: rtl/ientry_target.sv
module ientry_target #(
    parameter int unsigned      XLEN       = 32,
    parameter logic [XLEN-1:0]  VEC_OFFSET = 'h600
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic            sel_ret,
    input  logic [XLEN-1:0] vbr,
    input  logic [XLEN-1:0] spc,
    output logic [XLEN-1:0] redirect_pc
);

    logic [XLEN-1:0] handler_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    handler_q <= '0;
        else if (take) handler_q <= vbr + VEC_OFFSET;
    end

    assign redirect_pc = sel_ret ? spc : handler_q;

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
    parameter int unsigned     XLEN       = 32,
    parameter int unsigned     CODE_W     = 12,
    parameter logic [XLEN-1:0] VEC_OFFSET = 'h600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    input  logic [CODE_W-1:0] irq_code,
    input  logic              insn_end,
    input  logic [XLEN-1:0]   pc_cur,
    input  logic [XLEN-1:0]   vbr,
    input  logic              rte,
    input  logic              sr_we,
    input  logic [XLEN-1:0]   sr_wdata,
    output logic              redirect,
    output logic [XLEN-1:0]   redirect_pc,
    output logic [XLEN-1:0]   sr,
    output logic [XLEN-1:0]   ssr,
    output logic [XLEN-1:0]   spc,
    output logic [CODE_W-1:0] evt_a,
    output logic [CODE_W-1:0] evt_b
);

    logic take, do_rte, sel_ret;

    ientry_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_req  (irq_req),
        .insn_end (insn_end),
        .rte      (rte),
        .bl       (sr[irq_entry_pkg::SR_BL_BIT]),
        .take     (take),
        .do_rte   (do_rte),
        .redirect (redirect),
        .sel_ret  (sel_ret)
    );

    ientry_ctx #(.XLEN(XLEN), .CODE_W(CODE_W)) u_ctx (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .do_rte   (do_rte),
        .sr_we    (sr_we),
        .sr_wdata (sr_wdata),
        .pc_cur   (pc_cur),
        .irq_code (irq_code),
        .sr       (sr),
        .ssr      (ssr),
        .spc      (spc),
        .evt_a    (evt_a),
        .evt_b    (evt_b)
    );

    ientry_target #(.XLEN(XLEN), .VEC_OFFSET(VEC_OFFSET)) u_tgt (
        .clk         (clk),
        .rst_n       (rst_n),
        .take        (take),
        .sel_ret     (sel_ret),
        .vbr         (vbr),
        .spc         (spc),
        .redirect_pc (redirect_pc)
    );

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
    parameter int unsigned     XLEN       = 32,
    parameter int unsigned     CODE_W     = 12,
    parameter logic [XLEN-1:0] VEC_OFFSET = 'h600
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_req,
    input logic              insn_end,
    input logic [XLEN-1:0]   vbr,
    input logic              rte,
    input logic              redirect,
    input logic [XLEN-1:0]   redirect_pc,
    input logic [XLEN-1:0]   sr,
    input logic [XLEN-1:0]   ssr,
    input logic [XLEN-1:0]   spc,
    input logic [CODE_W-1:0] evt_a,
    input logic [CODE_W-1:0] evt_b
);

    // R6
    redirect_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !redirect);

    // R2
    entry_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && !$past(rte)) |-> ($past(insn_end) && $past(irq_req)));

    // R5
    entry_sr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && !$past(rte)) |-> (sr[30:28] == 3'b111 && sr[7:4] == ssr[7:4]));

    // R3
    evt_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && !$past(rte)) |-> (evt_a == evt_b));

    // R6
    entry_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && !$past(rte)) |-> (redirect_pc == $past(vbr) + VEC_OFFSET));

    // R7
    blocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr[28] && !rte) |=> !redirect);

    // R8
    return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rte && !redirect) |=> (redirect && redirect_pc == spc && sr == $past(ssr)));

endmodule

bind irq_entry_seq irq_entry_chk #(
    .XLEN(XLEN), .CODE_W(CODE_W), .VEC_OFFSET(VEC_OFFSET)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_req     (irq_req),
    .insn_end    (insn_end),
    .vbr         (vbr),
    .rte         (rte),
    .redirect    (redirect),
    .redirect_pc (redirect_pc),
    .sr          (sr),
    .ssr         (ssr),
    .spc         (spc),
    .evt_a       (evt_a),
    .evt_b       (evt_b)
);

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;

    localparam int XLEN = 32;
    localparam int CW   = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            irq_req = 1'b0;
    logic [CW-1:0]   irq_code = '0;
    logic            insn_end = 1'b0;
    logic [XLEN-1:0] pc_cur = '0;
    logic [XLEN-1:0] vbr = '0;
    logic            rte = 1'b0;
    logic            sr_we = 1'b0;
    logic [XLEN-1:0] sr_wdata = '0;
    logic            redirect;
    logic [XLEN-1:0] redirect_pc, sr, ssr, spc;
    logic [CW-1:0]   evt_a, evt_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_entry_seq u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_code(irq_code),
        .insn_end(insn_end), .pc_cur(pc_cur), .vbr(vbr), .rte(rte),
        .sr_we(sr_we), .sr_wdata(sr_wdata), .redirect(redirect),
        .redirect_pc(redirect_pc), .sr(sr), .ssr(ssr), .spc(spc),
        .evt_a(evt_a), .evt_b(evt_b)
    );

    function automatic logic [31:0] exp_entry_sr(input logic [31:0] s);
        return s | 32'h7000_0000;
    endfunction

    function automatic logic [31:0] exp_target(input logic [31:0] v);
        return v + 32'h600;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_sr(input logic [31:0] v);
        @(negedge clk); sr_we = 1'b1; sr_wdata = v;
        @(negedge clk); sr_we = 1'b0;
    endtask

    // Takes one interrupt; returns with irq_req low, one cycle after the redirect.
    task automatic take_irq(input logic [CW-1:0] code, input logic [31:0] pc,
                            input logic [31:0] vb, input int gap);
        logic [31:0] old_sr;
        old_sr = sr;
        @(negedge clk); irq_req = 1'b1; irq_code = code; vbr = vb; insn_end = 1'b0;
        repeat (gap) begin
            @(negedge clk);
            chk("R2", {31'd0, redirect}, 32'd0);
        end
        insn_end = 1'b1; pc_cur = pc;
        @(negedge clk); insn_end = 1'b0; irq_req = 1'b0; vbr = ~vb;
        chk("R2", {31'd0, redirect}, 32'd1);
        chk("R6", redirect_pc, exp_target(vb));
        chk("R3", {20'd0, evt_a}, {20'd0, code});
        chk("R3", {20'd0, evt_b}, {20'd0, code});
        chk("R4", ssr, old_sr);
        chk("R4", spc, pc);
        chk("R5", sr, exp_entry_sr(old_sr));
        @(negedge clk);
        chk("R6", {31'd0, redirect}, 32'd0);
    endtask

    task automatic do_return(input logic [31:0] exp_pc, input logic [31:0] exp_sr);
        @(negedge clk); rte = 1'b1;
        @(negedge clk); rte = 1'b0;
        chk("R8", {31'd0, redirect}, 32'd1);
        chk("R8", redirect_pc, exp_pc);
        chk("R8", sr, exp_sr);
        @(negedge clk);
        chk("R8", {31'd0, redirect}, 32'd0);
    endtask

    initial begin : watchdog
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000 && !done) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin : main
        logic [31:0] s0, e0, p0, v0;
        logic [CW-1:0] c0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", sr, 32'h5000_0000);
        chk("R1", ssr, 32'd0);
        chk("R1", spc, 32'd0);
        chk("R1", {20'd0, evt_a}, 32'd0);
        chk("R1", {31'd0, redirect}, 32'd0);
        rst_n = 1'b1;

        // R7: BL set out of reset, request with boundaries ignored
        @(negedge clk); irq_req = 1'b1; irq_code = 12'hABC; insn_end = 1'b1;
        repeat (5) begin
            @(negedge clk);
            chk("R7", {31'd0, redirect}, 32'd0);
        end
        chk("R7", {20'd0, evt_a}, 32'd0);
        chk("R7", spc, 32'd0);
        irq_req = 1'b0; insn_end = 1'b0;

        // R9: withdrawn request
        write_sr(32'h0000_00F0);
        @(negedge clk); irq_req = 1'b1; irq_code = 12'h111;
        @(negedge clk); irq_req = 1'b0;
        @(negedge clk); insn_end = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R9", {31'd0, redirect}, 32'd0);
        end
        insn_end = 1'b0;
        chk("R9", {20'd0, evt_a}, 32'd0);
        chk("R9", sr, 32'h0000_00F0);

        // Directed entry then return
        take_irq(12'h5A0, 32'h0000_1234, 32'h8000_0000, 1);
        do_return(32'h0000_1234, 32'h0000_00F0);

        // R7: request during handler ignored, then taken once BL cleared
        take_irq(12'h320, 32'hCAFE_0000, 32'h1000_0000, 3);
        s0 = sr; e0 = spc;
        @(negedge clk); irq_req = 1'b1; irq_code = 12'h7FF; insn_end = 1'b1;
        pc_cur = 32'h0000_4444; vbr = 32'h2000_0000;
        repeat (4) begin
            @(negedge clk);
            chk("R7", {31'd0, redirect}, 32'd0);
        end
        chk("R7", spc, e0);
        chk("R7", {20'd0, evt_b}, 32'h320);
        sr_we = 1'b1; sr_wdata = s0 & ~32'h1000_0000;
        @(negedge clk); sr_we = 1'b0;
        begin : wait_pending
            int k = 0;
            while (!redirect && k < 10) begin
                @(negedge clk); k++;
            end
        end
        irq_req = 1'b0; insn_end = 1'b0;
        chk("R7", {31'd0, redirect}, 32'd1);
        chk("R7", redirect_pc, 32'h2000_0600);
        chk("R7", spc, 32'h0000_4444);
        chk("R7", ssr, s0 & ~32'h1000_0000);
        chk("R3", {20'd0, evt_a}, 32'h7FF);
        @(negedge clk);
        do_return(32'h0000_4444, s0 & ~32'h1000_0000);

        // Random entries
        for (int i = 0; i < 40; i++) begin
            s0 = $urandom() & ~32'h1000_0000;
            p0 = $urandom();
            v0 = $urandom() & 32'hFFFF_F000;
            c0 = CW'($urandom());
            write_sr(s0);
            take_irq(c0, p0, v0, 1 + int'($urandom_range(0, 4)));
            if ($urandom_range(0, 1) == 1) begin
                do_return(p0, s0);
            end else begin
                write_sr(exp_entry_sr(s0) & ~32'h1000_0000);
                chk("R5", sr[7:4], s0[7:4]);
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule